// File: doc/BRIEF.md
# Temporal Frame-Modulation Dither

This block lowers the precision of a 12-bit-per-channel pixel stream to 6 or 8 bits per channel without the banding that plain truncation leaves. It spreads the discarded fraction over time and over space. The dropped low bits of each channel are rounded to the nearest quarter of an output step. That quarter picks a built-in on/off pattern, and the pattern decides whether this pixel in this frame is rounded up. Averaged over four frames, or over a small area of the screen, the output then comes close to the original value.

Each pixel arrives with its column and row coordinates. A frame-start strobe advances a two-bit frame phase counter. The sum of the coordinates, the frame phase and a programmable offset, taken modulo four, indexes into the selected pattern. Configuration inputs select whether dithering is on, the target depth, one of two pattern sets, and one of two patterns for each grey level. Two more inputs clear the phase and set its offset. When dithering is off, or when an unsupported depth is requested, pixels pass through unchanged. Software is expected to turn dithering off before it changes the depth or the patterns, and to turn it back on as the last step.

Top module: `frc_dither`

## Requirements
- R1: While `rst_n` is low on a clock edge, `out_valid` and `out_pix` become 0 and the frame phase becomes 0. The first frame after reset therefore uses phase 0.
- R2: Every output arrives exactly one cycle after its input. `out_valid` in cycle n+1 equals `in_valid` in cycle n.
- R3: If `cfg_enable` is 0, or `cfg_depth` is 2 (10-bit, unsupported) or 3, each pixel passes to `out_pix` unchanged.
- R4: With dithering on, `cfg_depth` 0 keeps the upper 6 bits of each channel and forces the low 6 bits to zero. `cfg_depth` 1 keeps the upper 8 bits and forces the low 4 bits to zero.
- R5: The dropped remainder `rem` of width d (d is 6 or 4) is turned into a quarter count q = (rem + 2^(d-3)) >> (d-2), which ranges from 0 to 4. If q is 0, the channel is never rounded up. If q is 4, it is always rounded up.
- R6: For q of 1, 2 or 3, the channel is rounded up when bit p of the pattern mask M is set, where p = (x + y + frame + `cfg_phase_ofs`) mod 4. The pattern index is i = 2*s + `cfg_level`, where s is `cfg_grey_sel` bit q-1. For q=1, M = 1<<i. For q=3, M = ~(1<<i) & 4'hF. For q=2, M is 4'h5, 4'hA, 4'h3 or 4'hC for i = 0, 1, 2 and 3.
- R7: The frame phase increments by one, modulo 4, at each clock edge where `frame_start` is 1. Over four consecutive frames at a fixed position, a channel with quarter count q is rounded up exactly q times.
- R8: While `cfg_phase_clr` is 1, the frame phase is held at 0, even if `frame_start` is 1. `cfg_phase_ofs` is added to the phase index.
- R9: A round-up never wraps. If the kept upper bits are all ones, the output stays at the maximum code.
- R10: The three channels are processed independently. Channel k occupies bits [12k+11:12k] of `in_pix` and `out_pix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Three 12-bit channels, channel 0 in the low bits |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| cfg_enable | input | 1 | Turns temporal dithering on |
| cfg_depth | input | 2 | Target depth: 0 = 6 bits, 1 = 8 bits, 2 and 3 = bypass |
| cfg_level | input | 1 | Selects the pattern set |
| cfg_grey_sel | input | 3 | Pattern choice for the 0.25 (bit 0), 0.5 (bit 1) and 0.75 (bit 2) grey levels |
| cfg_phase_clr | input | 1 | Holds the frame phase at zero |
| cfg_phase_ofs | input | 2 | Offset added to the phase index |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 36 | Reduced pixel, left-aligned, with the low bits zeroed |

## Verification
The hardest cases to reach are those that depend on the hidden frame phase. Its effect can be seen only through which pixels round up. The bench keeps its own copy of the phase, drives frame-start pulses between pixels, and compares every output with a model of the quarter rounding and the pattern masks. It repeats one pixel at a fixed position over four frames and counts how often each channel rounds up. It also asserts the phase clear together with frame-start pulses, then shows at the outputs that the phase stayed at zero and that the offset moves the pattern.

// File: rtl/frc_pkg.sv
// Package: shared constants and the built-in pattern masks for the
// frame-modulation dither. Assumes a four-entry phase cycle.
package frc_pkg;

    localparam int FRC_PHASES = 4;
    localparam int PHASE_W    = $clog2(FRC_PHASES);
    localparam int QTR_W      = 3;

    typedef enum logic [1:0] {
        DEPTH_6   = 2'd0,
        DEPTH_8   = 2'd1,
        DEPTH_10  = 2'd2,
        DEPTH_RSV = 2'd3
    } depth_e;

    // Mask over the four phases for a grey level (1..3 quarters),
    // a pattern set and a per-level pattern choice.
    function automatic logic [FRC_PHASES-1:0] frc_mask(
        input logic       level,
        input logic [1:0] grey,
        input logic       sel
    );
        logic [FRC_PHASES-1:0] single;
        logic [FRC_PHASES-1:0] mask;
        single = 4'b0001 << {sel, level};
        case (grey)
            2'd1:    mask = single;
            2'd3:    mask = ~single;
            2'd2: begin
                case ({sel, level})
                    2'd0:    mask = 4'b0101;
                    2'd1:    mask = 4'b1010;
                    2'd2:    mask = 4'b0011;
                    default: mask = 4'b1100;
                endcase
            end
            default: mask = '0;
        endcase
        return mask;
    endfunction

endpackage

// File: rtl/frc_frame_ctr.sv
// Module: frame phase counter. Advances once per frame-start strobe and
// wraps modulo the phase count. A clear input holds it at zero and takes
// priority over the strobe. Assumes the strobe lasts a single cycle per frame.
module frc_frame_ctr #(
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               clr,
    output logic [PHASE_W-1:0] count
);

    // Phase register: reset, clear, or advance on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (frame_start) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/frc_pattern_lut.sv
// Module: round-up decision. Turns a quarter count and a phase index into a
// single round-up bit using the built-in masks. Assumes the quarter count
// lies in 0..4; any value above 3 means always round up.
module frc_pattern_lut
    import frc_pkg::*;
(
    input  logic               level,
    input  logic [2:0]         grey_sel,
    input  logic [QTR_W-1:0]   qtr,
    input  logic [PHASE_W-1:0] phase,
    output logic               round_up
);

    logic [FRC_PHASES-1:0] mask;

    // Pick the mask for the quarter count, then index it by phase.
    always_comb begin
        mask     = '0;
        round_up = 1'b0;
        case (qtr)
            3'd0: round_up = 1'b0;
            3'd1: begin
                mask     = frc_mask(level, 2'd1, grey_sel[0]);
                round_up = mask[phase];
            end
            3'd2: begin
                mask     = frc_mask(level, 2'd2, grey_sel[1]);
                round_up = mask[phase];
            end
            3'd3: begin
                mask     = frc_mask(level, 2'd3, grey_sel[2]);
                round_up = mask[phase];
            end
            default: round_up = 1'b1;
        endcase
    end

endmodule

// File: rtl/frc_channel.sv
// Module: one colour channel. Quantises the dropped remainder to quarters,
// asks the pattern lookup whether to round up, and saturates at the top code.
// The output is left-aligned with zeroed low bits. Purely combinational;
// both drop widths must be at least 3.
module frc_channel
    import frc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int DROP_COARSE = 6,
    parameter int DROP_FINE   = 4
) (
    input  logic [DATA_W-1:0]  pix_in,
    input  logic               fine_sel,
    input  logic [PHASE_W-1:0] phase,
    input  logic               level,
    input  logic [2:0]         grey_sel,
    output logic [DATA_W-1:0]  pix_out
);

    localparam int KEEP_C = DATA_W - DROP_COARSE;
    localparam int KEEP_F = DATA_W - DROP_FINE;
    localparam logic [DROP_COARSE:0] HALF_C = (DROP_COARSE+1)'(1) << (DROP_COARSE - 3);
    localparam logic [DROP_FINE:0]   HALF_F = (DROP_FINE+1)'(1) << (DROP_FINE - 3);

    logic [DROP_COARSE:0] sum_c;
    logic [DROP_FINE:0]   sum_f;
    logic [QTR_W-1:0]     qtr;
    logic                 round_up;
    logic [KEEP_C-1:0]    trunc_c, res_c;
    logic [KEEP_F-1:0]    trunc_f, res_f;

    // Remainder plus half a quarter, for both candidate depths.
    always_comb begin
        sum_c = {1'b0, pix_in[DROP_COARSE-1:0]} + HALF_C;
        sum_f = {1'b0, pix_in[DROP_FINE-1:0]} + HALF_F;
        qtr   = fine_sel ? sum_f[DROP_FINE -: QTR_W] : sum_c[DROP_COARSE -: QTR_W];
    end

    frc_pattern_lut u_lut (
        .level    (level),
        .grey_sel (grey_sel),
        .qtr      (qtr),
        .phase    (phase),
        .round_up (round_up)
    );

    // Add the round-up bit unless the kept bits are already all ones.
    always_comb begin
        trunc_c = pix_in[DATA_W-1:DROP_COARSE];
        trunc_f = pix_in[DATA_W-1:DROP_FINE];
        res_c   = (round_up && !(&trunc_c)) ? KEEP_C'(trunc_c + 1'b1) : trunc_c;
        res_f   = (round_up && !(&trunc_f)) ? KEEP_F'(trunc_f + 1'b1) : trunc_f;
        pix_out = fine_sel ? {res_f, {DROP_FINE{1'b0}}} : {res_c, {DROP_COARSE{1'b0}}};
    end

endmodule

// File: rtl/frc_dither.sv
// Module: top of the frame-modulation dither. Forms the phase index from the
// coordinates, frame phase and offset, runs one channel slice per colour, and
// registers the result with one cycle of latency. Unsupported depths and a
// disabled block pass pixels through. Configuration is expected to be
// changed only while dithering is off.
module frc_dither
    import frc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NUM_CH      = 3,
    parameter int COORD_W     = 12,
    parameter int DROP_COARSE = 6,
    parameter int DROP_FINE   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_CH*DATA_W-1:0] in_pix,
    input  logic [COORD_W-1:0]       in_x,
    input  logic [COORD_W-1:0]       in_y,
    input  logic                     frame_start,
    input  logic                     cfg_enable,
    input  logic [1:0]               cfg_depth,
    input  logic                     cfg_level,
    input  logic [2:0]               cfg_grey_sel,
    input  logic                     cfg_phase_clr,
    input  logic [PHASE_W-1:0]       cfg_phase_ofs,
    output logic                     out_valid,
    output logic [NUM_CH*DATA_W-1:0] out_pix
);

    localparam int PIX_W = NUM_CH * DATA_W;

    logic [PHASE_W-1:0] frame_cnt;
    logic [PHASE_W-1:0] phase;
    logic               dith_on;
    logic               fine_sel;
    logic [PIX_W-1:0]   dith_pix;

    frc_frame_ctr #(.PHASE_W(PHASE_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .clr         (cfg_phase_clr),
        .count       (frame_cnt)
    );

    // Phase index and mode decode shared by all channels.
    always_comb begin
        phase    = in_x[PHASE_W-1:0] + in_y[PHASE_W-1:0] + frame_cnt + cfg_phase_ofs;
        dith_on  = cfg_enable && ((cfg_depth == DEPTH_6) || (cfg_depth == DEPTH_8));
        fine_sel = (cfg_depth == DEPTH_8);
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        frc_channel #(
            .DATA_W      (DATA_W),
            .DROP_COARSE (DROP_COARSE),
            .DROP_FINE   (DROP_FINE)
        ) u_ch (
            .pix_in   (in_pix[k*DATA_W +: DATA_W]),
            .fine_sel (fine_sel),
            .phase    (phase),
            .level    (cfg_level),
            .grey_sel (cfg_grey_sel),
            .pix_out  (dith_pix[k*DATA_W +: DATA_W])
        );
    end

    // Output register: one cycle of latency, bypass when dithering is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pix <= dith_on ? dith_pix : in_pix;
            end
        end
    end

endmodule

// File: rtl/frc_dither_chk.sv
// Module: property checker for frc_dither, attached with a bind. It checks
// channel 0 for the per-channel rules and the frame phase through the
// internal counter output.
module frc_dither_chk #(
    parameter int DATA_W  = 12,
    parameter int NUM_CH  = 3,
    parameter int PHASE_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [NUM_CH*DATA_W-1:0] in_pix,
    input logic                     frame_start,
    input logic                     cfg_enable,
    input logic [1:0]               cfg_depth,
    input logic                     cfg_phase_clr,
    input logic [PHASE_W-1:0]       frame_cnt,
    input logic                     out_valid,
    input logic [NUM_CH*DATA_W-1:0] out_pix
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_pix == '0 && frame_cnt == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!cfg_enable || cfg_depth[1])) |=> (out_pix == $past(in_pix)));

    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable && !cfg_depth[1]) |=> (out_pix[3:0] == 4'h0));

    // R5
    zero_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable && cfg_depth == 2'd1 && in_pix[3:0] == 4'h0)
        |=> (out_pix[DATA_W-1:0] == $past(in_pix[DATA_W-1:0])));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable && cfg_depth == 2'd0)
        |=> ((out_pix[11:6] == $past(in_pix[11:6])) ||
             (out_pix[11:6] == $past(in_pix[11:6]) + 6'd1)));

    // R7
    frame_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !cfg_phase_clr) |=> (frame_cnt == $past(frame_cnt) + 1'b1));

    // R8
    frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_phase_clr |=> (frame_cnt == '0));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable && cfg_depth == 2'd0 && in_pix[11:6] == 6'h3F)
        |=> (out_pix[11:6] == 6'h3F));

endmodule

bind frc_dither frc_dither_chk #(
    .DATA_W  (DATA_W),
    .NUM_CH  (NUM_CH),
    .PHASE_W (frc_pkg::PHASE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_pix        (in_pix),
    .frame_start   (frame_start),
    .cfg_enable    (cfg_enable),
    .cfg_depth     (cfg_depth),
    .cfg_phase_clr (cfg_phase_clr),
    .frame_cnt     (frame_cnt),
    .out_valid     (out_valid),
    .out_pix       (out_pix)
);

// File: tb/frc_dither_bench.sv
// Directed bench for frc_dither: one task per scenario, each checking itself.
// Inputs change on falling edges; outputs are sampled on falling edges.
module frc_dither_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [35:0] in_pix;
    logic [11:0] in_x, in_y;
    logic        frame_start;
    logic        cfg_enable;
    logic [1:0]  cfg_depth;
    logic        cfg_level;
    logic [2:0]  cfg_grey_sel;
    logic        cfg_phase_clr;
    logic [1:0]  cfg_phase_ofs;
    logic        out_valid;
    logic [35:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_frame = 0;

    always #5 clk = ~clk;

    frc_dither u_frc_dither (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_x(in_x), .in_y(in_y), .frame_start(frame_start),
        .cfg_enable(cfg_enable), .cfg_depth(cfg_depth), .cfg_level(cfg_level),
        .cfg_grey_sel(cfg_grey_sel), .cfg_phase_clr(cfg_phase_clr),
        .cfg_phase_ofs(cfg_phase_ofs), .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Pattern mask as given in the requirement on pattern selection.
    function automatic int pat_mask(input int lvl, input int q, input int s);
        int idx;
        idx = 2 * s + lvl;
        if (q == 1) return 1 << idx;
        if (q == 3) return 15 & ~(1 << idx);
        case (idx)
            0: return 5;
            1: return 10;
            2: return 3;
            default: return 12;
        endcase
    endfunction

    // Expected value of one channel under the current configuration.
    function automatic logic [11:0] model(input logic [11:0] v, input int ph);
        int d, tr, rem, q, up, maxc, s;
        if (!cfg_enable || cfg_depth > 2'd1) return v;
        d    = (cfg_depth == 2'd0) ? 6 : 4;
        tr   = int'(v) >> d;
        rem  = int'(v) & ((1 << d) - 1);
        q    = (rem + (1 << (d - 3))) >> (d - 2);
        maxc = (1 << (12 - d)) - 1;
        if (q == 0) up = 0;
        else if (q >= 4) up = 1;
        else begin
            s  = int'(cfg_grey_sel[q-1]);
            up = (pat_mask(int'(cfg_level), q, s) >> ph) & 1;
        end
        if (tr < maxc) tr = tr + up;
        return 12'(tr << d);
    endfunction

    // Send one pixel, then check valid and data one cycle later.
    task automatic send(input string req, input logic [11:0] r, input logic [11:0] g,
                        input logic [11:0] b, input logic [11:0] x, input logic [11:0] y,
                        output logic [35:0] got);
        int ph;
        ph = (int'(x) + int'(y) + exp_frame + int'(cfg_phase_ofs)) % 4;
        in_pix = {b, g, r}; in_x = x; in_y = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = out_pix;
        check({req, " (R2 valid)"}, {35'd0, out_valid}, 36'd1);
        check(req, out_pix, {model(b, ph), model(g, ph), model(r, ph)});
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (!cfg_phase_clr) exp_frame = (exp_frame + 1) % 4;
    endtask

    task automatic t_reset();
        logic [35:0] got;
        check("R1 reset out_valid", {35'd0, out_valid}, 36'd0);
        check("R1 reset out_pix", out_pix, 36'd0);
        rst_n = 1'b1;
        cfg_enable = 1'b1; cfg_depth = 2'd1; cfg_level = 1'b0; cfg_grey_sel = 3'b000;
        send("R1 first frame phase", 12'h104, 12'h104, 12'h104, 12'd0, 12'd0, got);
        check("R1 frame zero after reset", got, {12'h110, 12'h110, 12'h110});
    endtask

    task automatic t_bypass();
        logic [35:0] got;
        cfg_enable = 1'b0; cfg_depth = 2'd1;
        send("R3 disabled", 12'h123, 12'h456, 12'h789, 12'd1, 12'd2, got);
        check("R3 disabled pass", got, {12'h789, 12'h456, 12'h123});
        cfg_enable = 1'b1; cfg_depth = 2'd2;
        send("R3 depth 10", 12'hABD, 12'h00F, 12'hFFF, 12'd3, 12'd0, got);
        check("R3 depth 10 pass", got, {12'hFFF, 12'h00F, 12'hABD});
        cfg_depth = 2'd3;
        send("R3 depth 3", 12'h5A5, 12'h3C3, 12'h0F1, 12'd2, 12'd2, got);
        check("R3 depth 3 pass", got, {12'h0F1, 12'h3C3, 12'h5A5});
        @(negedge clk);
        check("R2 idle valid low", {35'd0, out_valid}, 36'd0);
    endtask

    task automatic t_sweep(input logic [1:0] dep);
        logic [35:0] got;
        cfg_enable = 1'b1; cfg_depth = dep;
        for (int i = 0; i < 64; i++) begin
            logic [5:0] iv;
            iv = 6'(i);
            cfg_level    = iv[0];
            cfg_grey_sel = iv[3:1];
            cfg_phase_ofs = iv[5:4];
            send("R4 R6 R10 sweep", {iv, iv}, 12'(i * 37 + 5), 12'(4095 - i * 3),
                 12'(i), 12'(i * 3), got);
            if (i % 16 == 15) pulse_frame();
        end
        cfg_phase_ofs = 2'd0;
    endtask

    task automatic t_temporal();
        logic [35:0] got;
        int up_r, up_g, up_b;
        up_r = 0; up_g = 0; up_b = 0;
        cfg_enable = 1'b1; cfg_depth = 2'd1; cfg_level = 1'b1; cfg_grey_sel = 3'b101;
        for (int f = 0; f < 4; f++) begin
            send("R7 R10 temporal", 12'h204, 12'h308, 12'h40C, 12'd5, 12'd6, got);
            if (got[11:0]  != 12'h200) up_r++;
            if (got[23:12] != 12'h300) up_g++;
            if (got[35:24] != 12'h400) up_b++;
            pulse_frame();
        end
        check("R7 quarter ups over 4 frames", 36'(up_r), 36'd1);
        check("R7 half ups over 4 frames", 36'(up_g), 36'd2);
        check("R7 three-quarter ups over 4 frames", 36'(up_b), 36'd3);
    endtask

    task automatic t_phase();
        logic [35:0] got;
        cfg_enable = 1'b1; cfg_depth = 2'd1; cfg_level = 1'b0; cfg_grey_sel = 3'b000;
        cfg_phase_clr = 1'b1;
        @(negedge clk);
        exp_frame = 0;
        pulse_frame();
        pulse_frame();
        send("R8 clear holds phase", 12'h204, 12'h204, 12'h204, 12'd0, 12'd0, got);
        check("R8 phase held at zero", got, {12'h210, 12'h210, 12'h210});
        cfg_phase_clr = 1'b0;
        cfg_phase_ofs = 2'd1;
        send("R8 offset one", 12'h204, 12'h204, 12'h204, 12'd0, 12'd0, got);
        check("R8 offset moves pattern", got, {12'h200, 12'h200, 12'h200});
        cfg_phase_ofs = 2'd3;
        send("R8 offset three", 12'h204, 12'h204, 12'h204, 12'd1, 12'd0, got);
        check("R8 offset wraps", got, {12'h210, 12'h210, 12'h210});
        cfg_phase_ofs = 2'd0;
    endtask

    task automatic t_sat();
        logic [35:0] got;
        cfg_enable = 1'b1; cfg_level = 1'b0; cfg_grey_sel = 3'b000;
        cfg_depth = 2'd0;
        send("R9 saturate 6-bit", 12'hFFF, 12'hFC8, 12'h7FF, 12'd0, 12'd0, got);
        check("R9 R5 top code and carry", got, {12'h800, 12'hFC0, 12'hFC0});
        cfg_depth = 2'd1;
        send("R9 saturate 8-bit", 12'hFFF, 12'hFFE, 12'h0FF, 12'd2, 12'd1, got);
        check("R9 8-bit top code", got, {12'h100, 12'hFF0, 12'hFF0});
    endtask

    task automatic t_zero();
        logic [35:0] got;
        cfg_enable = 1'b1; cfg_depth = 2'd1; cfg_level = 1'b1; cfg_grey_sel = 3'b111;
        for (int x = 0; x < 4; x++) begin
            send("R5 zero and full remainder", 12'h120, 12'h3A1, 12'h12E, 12'(x), 12'd0, got);
            check("R5 no round-up at zero, always at four", got, {12'h130, 12'h3A0, 12'h120});
        end
        cfg_depth = 2'd0;
        send("R4 depth0 low bits", 12'h047, 12'h0C0, 12'hABC, 12'd7, 12'd9, got);
        check("R4 6-bit low zero", {30'd0, got[5:0]}, 36'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; in_x = '0; in_y = '0;
        frame_start = 1'b0; cfg_enable = 1'b0; cfg_depth = 2'd0; cfg_level = 1'b0;
        cfg_grey_sel = 3'b000; cfg_phase_clr = 1'b0; cfg_phase_ofs = 2'd0;
        repeat (3) @(negedge clk);
        t_reset();
        t_bypass();
        t_sweep(2'd0);
        t_sweep(2'd1);
        t_temporal();
        t_phase();
        t_sat();
        t_zero();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule